// File: doc/BRIEF.md
# Programmable Address Window Decoder

This block assigns a target identifier to each transaction from its system address. Software programs up to eight address windows through a 32-bit register port. Each window has a 1 MiB-aligned base, an inclusive last 1 MiB unit, a 4-bit target and separate security guards for reads and for writes. Addresses that fall in no enabled window go to a programmable fallback target. Window 0 is already open at reset and points at the internal configuration space, so the register port can be reached before any software runs.

The decode port takes the address bits above the 1 MiB boundary (bits 47:20), a write flag and a secure flag. One cycle later it returns the target, a hit flag and a security-error flag. The lower twenty address bits cannot change the routing, so they are not brought into the block.

Top module: `addr_window_decoder`

## Requirements
- R1: After reset, window 0 is enabled. Its target is RST_W0_TID (default 4'hE) and it covers 1 MiB units 0x000 to 0x00F. Every other window reads back as all-zero registers and is disabled. The fallback target is 0, and out_valid, out_hit, out_sec_err and out_tid are 0.
- R2: Window n is at register offset 0x10*n, and only word-aligned accesses have effect. The registers within a window are:
  - control (+0x0): enable in bit 0, target in bits 11:8.
  - guard (+0x4): write-guard in bit 0, read-guard in bit 1.
  - base (+0x8) and last (+0xC): address bits 47:20 in register bits 31:4, with bits 3:0 always reading 0.
  The fallback register at 0x100 holds the target in bits 3:0. Unused bits read 0, and unmapped offsets read 0.
- R3: A window matches when it is enabled and base[31:4] <= dec_addr_mb <= last[31:4]. Both bounds are inclusive.
- R4: An address that matches no enabled window returns out_hit=0, out_sec_err=0 and out_tid equal to the fallback target.
- R5: When several enabled windows match, the one with the lowest index decides the result.
- R6: Clearing a window's enable removes it from decoding. Its target, base and last registers keep their values, and setting the enable again restores the same mapping.
- R7: A new target written to an enabled window applies to every decode that is presented after that write.
- R8: A non-secure write to a window whose write-guard is set gives out_sec_err=1, out_hit=0 and out_tid=0. A non-secure read to a window whose read-guard is set gives the same result. The two guards act independently. Secure traffic is never blocked.
- R9: The decode outputs are registered, so they reflect the inputs from the previous clock edge. out_valid repeats dec_valid one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 9 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr (combinational) |
| dec_valid | input | 1 | Decode request valid |
| dec_addr_mb | input | 28 | Transaction address bits 47:20 |
| dec_write | input | 1 | 1 for write, 0 for read |
| dec_secure | input | 1 | 1 for secure transaction |
| out_valid | output | 1 | Decode result valid |
| out_tid | output | 4 | Selected target |
| out_hit | output | 1 | A window matched and passed the security check |
| out_sec_err | output | 1 | Security guard blocked the transaction |

## Verification
All window state stays inside the block, but the register port shows it directly, and a single decode shows its effect on routing one cycle later. A wrong bound, a stale enable or a wrong priority order misroutes particular 1 MiB units. A sweep over every unit that touches the programmed windows, with all four write/secure combinations, therefore exposes such a fault on the first vector that lands in the faulty region. Register readback after enable toggling shows whether disabling a window corrupted its stored range.

// File: rtl/addr_window_decoder.sv
module addr_window_decoder #(
  parameter int          NUM_WIN       = 8,
  parameter int          ADDR_W        = 48,
  parameter int          TID_W         = 4,
  parameter int          RST_W0_TID    = 14,
  parameter logic [31:0] RST_W0_BASE   = 32'h0000_0000,
  parameter logic [31:0] RST_W0_LAST   = 32'h0000_00F0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [8:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              dec_valid,
  input  logic [ADDR_W-21:0] dec_addr_mb,
  input  logic              dec_write,
  input  logic              dec_secure,
  output logic              out_valid,
  output logic [TID_W-1:0]  out_tid,
  output logic              out_hit,
  output logic              out_sec_err
);

  localparam int UNIT_W = ADDR_W - 20;
  localparam int IW     = $clog2(NUM_WIN);

  logic [NUM_WIN-1:0]             en_q, wg_q, rg_q;
  logic [NUM_WIN-1:0][TID_W-1:0]  tid_q;
  logic [NUM_WIN-1:0][UNIT_W-1:0] base_q, last_q;
  logic [TID_W-1:0]               fb_q;

  wire          aligned = (cfg_addr[1:0] == 2'b00);
  wire          in_win  = aligned && !cfg_addr[8] && (32'(cfg_addr[7:4]) < NUM_WIN);
  wire          is_fb   = (cfg_addr == 9'h100);
  wire [IW-1:0] widx    = cfg_addr[IW+3:4];
  wire [1:0]    wreg    = cfg_addr[3:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_WIN; i++) begin
        en_q[i]   <= (i == 0);
        wg_q[i]   <= 1'b0;
        rg_q[i]   <= 1'b0;
        tid_q[i]  <= (i == 0) ? TID_W'(RST_W0_TID) : '0;
        base_q[i] <= (i == 0) ? RST_W0_BASE[4 +: UNIT_W] : '0;
        last_q[i] <= (i == 0) ? RST_W0_LAST[4 +: UNIT_W] : '0;
      end
      fb_q <= '0;
    end else if (cfg_wr) begin
      if (is_fb) fb_q <= cfg_wdata[TID_W-1:0];
      for (int i = 0; i < NUM_WIN; i++) begin
        if (in_win && widx == IW'(i)) begin
          case (wreg)
            2'd0: begin
              en_q[i]  <= cfg_wdata[0];
              tid_q[i] <= cfg_wdata[8 +: TID_W];
            end
            2'd1: begin
              wg_q[i] <= cfg_wdata[0];
              rg_q[i] <= cfg_wdata[1];
            end
            2'd2: base_q[i] <= cfg_wdata[4 +: UNIT_W];
            default: last_q[i] <= cfg_wdata[4 +: UNIT_W];
          endcase
        end
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (in_win) begin
      case (wreg)
        2'd0: begin
          cfg_rdata[0]           = en_q[widx];
          cfg_rdata[8 +: TID_W]  = tid_q[widx];
        end
        2'd1: cfg_rdata[1:0] = {rg_q[widx], wg_q[widx]};
        2'd2: cfg_rdata[4 +: UNIT_W] = base_q[widx];
        default: cfg_rdata[4 +: UNIT_W] = last_q[widx];
      endcase
    end else if (is_fb) begin
      cfg_rdata[TID_W-1:0] = fb_q;
    end
  end

  logic          found;
  logic [IW-1:0] sel;
  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (en_q[i] && dec_addr_mb >= base_q[i] && dec_addr_mb <= last_q[i]) begin
        found = 1'b1;
        sel   = IW'(i);
      end
    end
  end

  wire             blocked = found && !dec_secure && (dec_write ? wg_q[sel] : rg_q[sel]);
  wire [TID_W-1:0] tid_d   = !found ? fb_q : (blocked ? '0 : tid_q[sel]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_tid     <= '0;
      out_hit     <= 1'b0;
      out_sec_err <= 1'b0;
    end else begin
      out_valid   <= dec_valid;
      out_tid     <= tid_d;
      out_hit     <= found && !blocked;
      out_sec_err <= blocked;
    end
  end

  assert_err_blocks_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_sec_err |-> (!out_hit && out_tid == '0));

  assert_err_needs_nonsecure_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dec_secure |=> !out_sec_err);

  assert_valid_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> out_valid);

  assert_miss_uses_fallback_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!found) |=> (!out_hit && !out_sec_err && out_tid == $past(fb_q)));

  assert_base_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_wr && in_win && wreg == 2'd2) |=> $stable(base_q));

  assert_last_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_wr && in_win && wreg == 2'd3) |=> $stable(last_q));

endmodule

// File: tb/addr_window_decoder_bench.sv
module addr_window_decoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [8:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        dec_valid = 1'b0;
  logic [27:0] dec_addr_mb = '0;
  logic        dec_write = 1'b0;
  logic        dec_secure = 1'b0;
  logic        out_valid;
  logic [3:0]  out_tid;
  logic        out_hit;
  logic        out_sec_err;

  addr_window_decoder u_addr_window_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dec_valid(dec_valid),
    .dec_addr_mb(dec_addr_mb), .dec_write(dec_write), .dec_secure(dec_secure),
    .out_valid(out_valid), .out_tid(out_tid), .out_hit(out_hit),
    .out_sec_err(out_sec_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;

  logic        m_en [NW];
  logic        m_wg [NW];
  logic        m_rg [NW];
  logic [3:0]  m_tid [NW];
  logic [27:0] m_base [NW];
  logic [27:0] m_last [NW];
  logic [3:0]  m_fb;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
    if (a == 9'h100) m_fb = d[3:0];
    else if (a[8] == 1'b0 && a[1:0] == 2'b00 && a[7:4] < NW) begin
      case (a[3:2])
        2'd0: begin m_en[a[7:4]] = d[0]; m_tid[a[7:4]] = d[11:8]; end
        2'd1: begin m_wg[a[7:4]] = d[0]; m_rg[a[7:4]] = d[1]; end
        2'd2: m_base[a[7:4]] = d[31:4];
        default: m_last[a[7:4]] = d[31:4];
      endcase
    end
  endtask

  task automatic reg_chk(input string tag, input logic [8:0] a, input logic [31:0] exp);
    @(negedge clk);
    cfg_addr = a;
    #1;
    chk(tag, cfg_rdata, exp);
  endtask

  function automatic logic [5:0] model(input logic [27:0] u, input logic w, input logic s);
    int k = -1;
    for (int i = NW - 1; i >= 0; i--)
      if (m_en[i] && u >= m_base[i] && u <= m_last[i]) k = i;
    if (k < 0) return {2'b00, m_fb};
    if (!s && (w ? m_wg[k] : m_rg[k])) return {2'b01, 4'h0};
    return {2'b10, m_tid[k]};
  endfunction

  function automatic int n_match(input logic [27:0] u);
    int c = 0;
    for (int i = 0; i < NW; i++)
      if (m_en[i] && u >= m_base[i] && u <= m_last[i]) c++;
    return c;
  endfunction

  task automatic dec_chk(input logic [27:0] u, input logic w, input logic s);
    logic [5:0] exp;
    string tag;
    exp = model(u, w, s);
    if (exp[4]) tag = "R8";
    else if (!exp[5]) tag = "R4";
    else if (n_match(u) > 1) tag = "R5";
    else tag = "R3";
    @(negedge clk);
    dec_valid = 1'b1; dec_addr_mb = u; dec_write = w; dec_secure = s;
    @(negedge clk);
    dec_valid = 1'b0;
    chk(tag, {26'b0, out_hit, out_sec_err, out_tid}, {26'b0, exp});
  endtask

  task automatic sweep(input logic [27:0] lo, input logic [27:0] hi);
    for (logic [28:0] u = {1'b0, lo}; u <= {1'b0, hi}; u++)
      for (int m = 0; m < 4; m++)
        dec_chk(u[27:0], m[1], m[0]);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL R9: watchdog expired, actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NW; i++) begin
      m_en[i] = (i == 0); m_wg[i] = 0; m_rg[i] = 0;
      m_tid[i] = (i == 0) ? 4'hE : 4'h0;
      m_base[i] = 0; m_last[i] = (i == 0) ? 28'h00F : 28'h0;
    end
    m_fb = 4'h0;
    #(CLK_PERIOD * 3);
    @(negedge clk);
    chk("R1 outputs", {28'b0, out_valid, out_hit, out_sec_err, 1'b0} | {28'b0, out_tid}, 32'h0);
    rst_n = 1'b1;

    // R1: reset register contents
    reg_chk("R1 w0 ctrl", 9'h000, 32'h0000_0E01);
    reg_chk("R1 w0 last", 9'h00C, 32'h0000_00F0);
    reg_chk("R1 fallback", 9'h100, 32'h0);
    for (int i = 1; i < NW; i++) begin
      reg_chk("R1 ctrl", 9'(16*i), 32'h0);
      reg_chk("R1 last", 9'(16*i + 12), 32'h0);
    end
    sweep(28'h000, 28'h012);

    // R2: register layout, low nibble of bounds reads zero
    reg_wr(9'h100, 32'hFFFF_FFF3);
    reg_chk("R2 fallback", 9'h100, 32'h3);
    reg_wr(9'h010, 32'h0000_0101); reg_wr(9'h018, 32'h0000_020F); reg_wr(9'h01C, 32'h0000_02FF);
    reg_chk("R2 base", 9'h018, 32'h0000_0200);
    reg_chk("R2 last", 9'h01C, 32'h0000_02F0);
    reg_chk("R2 ctrl", 9'h010, 32'h0000_0101);
    reg_chk("R2 misaligned", 9'h012, 32'h0);
    reg_wr(9'h020, 32'h0000_0201); reg_wr(9'h028, 32'h0000_0280); reg_wr(9'h02C, 32'h0000_0370);
    reg_wr(9'h030, 32'h0000_0301); reg_wr(9'h038, 32'h0000_0400); reg_wr(9'h03C, 32'h0000_0400);
    reg_wr(9'h040, 32'h0000_0401); reg_wr(9'h044, 32'h1); reg_wr(9'h048, 32'h500); reg_wr(9'h04C, 32'h5F0);
    reg_wr(9'h050, 32'h0000_0501); reg_wr(9'h054, 32'h2); reg_wr(9'h058, 32'h600); reg_wr(9'h05C, 32'h6F0);
    reg_wr(9'h060, 32'h0000_0601); reg_wr(9'h064, 32'h3); reg_wr(9'h068, 32'h700); reg_wr(9'h06C, 32'h7F0);
    reg_wr(9'h070, 32'h0000_0701); reg_wr(9'h078, 32'hFFFF_FF00); reg_wr(9'h07C, 32'hFFFF_FFF0);
    reg_chk("R2 guard", 9'h054, 32'h2);
    reg_chk("R2 unmapped", 9'h080, 32'h0);

    // R3 R4 R5 R8 sweep across programmed windows
    sweep(28'h000, 28'h082);
    sweep(28'hFFFFFFC, 28'hFFFFFFF);
    sweep(28'hFFFFEFE, 28'hFFFFF01);

    // R6: disable and restore window 1
    reg_wr(9'h010, 32'h0000_0100);
    reg_chk("R6 base kept", 9'h018, 32'h0000_0200);
    reg_chk("R6 last kept", 9'h01C, 32'h0000_02F0);
    reg_chk("R6 tid kept", 9'h010, 32'h0000_0100);
    sweep(28'h01E, 28'h02A);
    reg_wr(9'h010, 32'h0000_0101);
    sweep(28'h01E, 28'h02A);

    // R7: retarget enabled window 3 in place
    reg_wr(9'h030, 32'h0000_0901);
    dec_chk(28'h040, 1'b0, 1'b1);
    chk("R7 new target", {28'b0, out_tid}, 32'h9);

    // R9: one-cycle latency and valid tracking
    @(negedge clk);
    dec_valid = 1'b1; dec_addr_mb = 28'h025; dec_secure = 1'b1; dec_write = 1'b0;
    #1;
    chk("R9 not yet", {31'b0, out_valid}, 32'h0);
    @(negedge clk);
    dec_valid = 1'b0;
    chk("R9 valid", {31'b0, out_valid}, 32'h1);
    chk("R9 tid", {28'b0, out_tid}, 32'h1);
    @(negedge clk);
    chk("R9 valid drop", {31'b0, out_valid}, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule